// File: doc/BRIEF.md
# Flash Command Sequencer with Erase Engine

This block sits behind a bus decoder. It sees every byte write as an address and a data pair. It watches those writes for multi-write software command sequences and carries out byte program, sector erase and whole-array erase on a small behavioural byte array. The array is split into a boot block, two parameter blocks and eight main blocks. Each operation is timed inside the block by a cycle counter, and a busy flag is high while that counter runs. When the count ends, the sequencer goes back to serving reads.

Every command starts with the same unlock prefix: AAh written at 5555h, then 55h written at 2AAAh. A write that does not match the step the sequencer expects drops any partial sequence. A boot-lock input protects the boot block from programming and from erase.

Top module: `flash_seq`

## Requirements
- R1: After reset, busy_o is 0 and every byte of the array reads FFh.
- R2: The write sequence AAh@5555h, 55h@2AAAh, A0h@5555h, then d@a, programs byte a. When the operation completes, the byte at a holds its old value AND d. Bits never return from 0 to 1 through programming.
- R3: busy_o rises in the cycle after the final write of a sequence. It stays high for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase. It then falls, and the next command is accepted at once.
- R4: The sequence AAh, 55h, 80h, AAh, 55h, with the first three writes at 5555h, 2AAAh, 5555h and the next two at 5555h, 2AAAh, followed by 30h at address s, erases only the sector containing s. With U = UNIT the sectors are: boot [0, 2U), parameter 1 [2U, 3U), parameter 2 [3U, 4U), and main k [4U+4Uk, 8U+4Uk) for k = 0..7.
- R5: The same five-write prefix followed by 10h@5555h erases the whole array. When boot_lock_i is 1, the boot block is kept.
- R6: When boot_lock_i is 1, a program or sector erase that targets the boot block leaves it unchanged. Other sectors are not affected by the lock.
- R7: Every write that arrives while busy_o is high is ignored. A partial command sent during an operation has no effect after the operation ends.
- R8: A write that does not match the expected address and data for the current step returns the sequencer to idle. A following write is then treated as the start of a new command. Command writes do not change array contents.
- R9: rdata_o shows the byte at addr_i when idle. It reads FFh while busy_o is high or when addr_i is beyond the 36U-byte array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | One-cycle write event strobe |
| addr_i | input | AW | Write address and read address |
| wdata_i | input | 8 | Write data byte |
| boot_lock_i | input | 1 | Boot block lockout enable |
| rdata_o | output | 8 | Read data |
| busy_o | output | 1 | Internal operation in progress |

## Verification
The assertions assume that wr_i is a single-cycle strobe whose address and data are valid in the same cycle. They also assume that boot_lock_i does not change in the cycle an operation completes, so that the boot-preservation check sees the lock value the array used. The bench keeps to these rules: it drives each write for exactly one clock with one idle clock after it, and it changes the lock only while the sequencer is idle. Some writes are sent deliberately during a busy interval, to exercise the ignore rule.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {OP_PROG, OP_SECT, OP_CHIP} op_e;
  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PDATA, S_ERA1, S_ERA2, S_ERA3, S_BUSY
  } seq_st_e;
  localparam logic [15:0] ADDR_KEY1 = 16'h5555;
  localparam logic [15:0] ADDR_KEY2 = 16'h2AAA;
  localparam logic [7:0]  DAT_KEY1  = 8'hAA;
  localparam logic [7:0]  DAT_KEY2  = 8'h55;
  localparam logic [7:0]  DAT_PROG  = 8'hA0;
  localparam logic [7:0]  DAT_ERASE = 8'h80;
  localparam logic [7:0]  DAT_CHIP  = 8'h10;
  localparam logic [7:0]  DAT_SECT  = 8'h30;
endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          done_i,
  output logic          start_o,
  output op_e           start_op_o,
  output op_e           op_o,
  output logic [AW-1:0] op_addr_o,
  output logic [7:0]    op_data_o,
  output logic          busy_o
);
  localparam logic [AW-1:0] A1 = AW'(ADDR_KEY1);
  localparam logic [AW-1:0] A2 = AW'(ADDR_KEY2);

  seq_st_e st_q, st_d;
  logic key1, key2;

  assign key1 = (addr_i == A1) && (wdata_i == DAT_KEY1);
  assign key2 = (addr_i == A2) && (wdata_i == DAT_KEY2);

  always_comb begin
    st_d       = st_q;
    start_o    = 1'b0;
    start_op_o = OP_PROG;
    if (st_q == S_BUSY) begin
      if (done_i) st_d = S_IDLE;
    end else if (wr_i) begin
      st_d = S_IDLE;
      unique case (st_q)
        S_IDLE: if (key1) st_d = S_UNL1;
        S_UNL1: if (key2) st_d = S_UNL2;
        S_UNL2: begin
          if (addr_i == A1 && wdata_i == DAT_PROG)  st_d = S_PDATA;
          if (addr_i == A1 && wdata_i == DAT_ERASE) st_d = S_ERA1;
        end
        S_PDATA: begin
          start_o = 1'b1;
          st_d    = S_BUSY;
        end
        S_ERA1: if (key1) st_d = S_ERA2;
        S_ERA2: if (key2) st_d = S_ERA3;
        S_ERA3: begin
          if (addr_i == A1 && wdata_i == DAT_CHIP) begin
            start_o = 1'b1; start_op_o = OP_CHIP; st_d = S_BUSY;
          end else if (wdata_i == DAT_SECT) begin
            start_o = 1'b1; start_op_o = OP_SECT; st_d = S_BUSY;
          end
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      op_o      <= OP_PROG;
      op_addr_o <= '0;
      op_data_o <= 8'hFF;
    end else begin
      st_q <= st_d;
      if (start_o) begin
        op_o      <= start_op_o;
        op_addr_o <= addr_i;
        op_data_o <= wdata_i;
      end
    end
  end

  assign busy_o = (st_q == S_BUSY);

  assert_wr_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_i |=> busy_o && $stable(op_addr_o) && $stable(op_data_o));
  assert_busy_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !busy_o);
  assert_start_raises_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> busy_o);
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic long_i,
  output logic done_o
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic          active_q;

  assign done_o = active_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= long_i ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
      active_q <= 1'b1;
    end else if (done_o) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_start_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
  assert_count_runs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !done_o |=> active_q);
endmodule

// File: rtl/flash_store.sv
module flash_store
  import flash_seq_pkg::*;
#(
  parameter int AW   = 16,
  parameter int UNIT = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  op_e           op_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic [7:0]    op_data_i,
  input  logic          lock_i,
  input  logic          busy_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 36 * UNIT;
  localparam int IW    = $clog2(DEPTH);

  function automatic logic [3:0] sec_of(input logic [AW-1:0] a);
    if (a < AW'(2 * UNIT))      return 4'd0;
    else if (a < AW'(3 * UNIT)) return 4'd1;
    else if (a < AW'(4 * UNIT)) return 4'd2;
    else if (a < AW'(DEPTH))    return 4'(32'd3 + 32'((a - AW'(4 * UNIT)) / AW'(4 * UNIT)));
    else                        return 4'hF;
  endfunction

  logic [DEPTH*8-1:0] mem_flat;
  logic [3:0]         tgt_sec;
  logic               tgt_in, rd_in;
  logic [IW-1:0]      tgt_idx, rd_idx;
  logic [7:0]         tgt_byte;

  assign tgt_sec  = sec_of(op_addr_i);
  assign tgt_in   = op_addr_i < AW'(DEPTH);
  assign tgt_idx  = op_addr_i[IW-1:0];
  assign tgt_byte = tgt_in ? mem_flat[tgt_idx*8 +: 8] : 8'hFF;
  assign rd_in    = rd_addr_i < AW'(DEPTH);
  assign rd_idx   = rd_addr_i[IW-1:0];
  assign rdata_o  = (busy_i || !rd_in) ? 8'hFF : mem_flat[rd_idx*8 +: 8];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic [3:0] WSEC = sec_of(AW'(i));
    logic [7:0] word_q;
    logic       prot;
    assign prot = lock_i && (WSEC == 4'd0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q <= 8'hFF;
      else if (done_i && !prot) begin
        unique case (op_i)
          OP_PROG: if (tgt_in && tgt_idx == IW'(i)) word_q <= word_q & op_data_i;
          OP_SECT: if (tgt_sec == WSEC) word_q <= 8'hFF;
          OP_CHIP: word_q <= 8'hFF;
          default: ;
        endcase
      end
    end
    assign mem_flat[i*8 +: 8] = word_q;
  end

  assert_prog_clears_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && op_i == OP_PROG && tgt_in |=> (tgt_byte & ~$past(tgt_byte)) == 8'h00);
  assert_boot_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && lock_i |=> mem_flat[7:0] == $past(mem_flat[7:0]));
  assert_idle_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(mem_flat));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int AW        = 16,
  parameter int UNIT      = 8,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          boot_lock_i,
  output logic [7:0]    rdata_o,
  output logic          busy_o
);
  logic          start, done;
  op_e           start_op, op;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;

  flash_cmd_fsm #(.AW(AW)) u_fsm (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .done_i(done), .start_o(start), .start_op_o(start_op), .op_o(op),
    .op_addr_o(op_addr), .op_data_o(op_data), .busy_o
  );

  flash_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
    .clk_i, .rst_ni, .start_i(start), .long_i(start_op != OP_PROG), .done_o(done)
  );

  flash_store #(.AW(AW), .UNIT(UNIT)) u_mem (
    .clk_i, .rst_ni, .done_i(done), .op_i(op), .op_addr_i(op_addr),
    .op_data_i(op_data), .lock_i(boot_lock_i), .busy_i(busy_o),
    .rd_addr_i(addr_i), .rdata_o
  );
endmodule

// File: tb/flash_seq_test.sv
`timescale 1ns/1ps
module flash_seq_test;
  localparam int PROG_CYC  = 16;
  localparam int ERASE_CYC = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        boot_lock_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        busy_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [8:0] e;
  logic [7:0] act;
  string      t;

  always #4 clk_i = ~clk_i;

  flash_seq #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) uut (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .boot_lock_i, .rdata_o, .busy_o
  );

  task automatic chk(input int a, input int x, input string tag);
    checks++;
    if (a != x) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, a, x);
    end
  endtask

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      act = e[8] ? {7'b0, busy_o} : rdata_o;
      chk(int'(act), int'(e[7:0]), t);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk_i); #1;
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  task automatic expect_rd(input logic [15:0] a, input logic [7:0] x, input string tag);
    @(posedge clk_i); #1;
    addr_i = a;
    exp_q.push_back({1'b0, x});
    tag_q.push_back(tag);
  endtask

  task automatic expect_busy(input logic b, input string tag);
    @(posedge clk_i); #1;
    exp_q.push_back({1'b1, 7'b0, b});
    tag_q.push_back(tag);
  endtask

  task automatic wait_idle();
    while (busy_o) begin @(posedge clk_i); #1; end
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy_o) begin n++; @(posedge clk_i); #1; end
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(a, d);
  endtask

  task automatic erase6(input logic [15:0] a, input logic [7:0] d);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(a, d);
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    expect_busy(1'b0, "R1 busy after reset");
    expect_rd(16'd0, 8'hFF, "R1 erased byte 0");
    expect_rd(16'd287, 8'hFF, "R1 erased last byte");
    expect_rd(16'd300, 8'hFF, "R9 out of range");

    prog(16'd5, 8'hA5);
    busy_len(n);
    chk(n, PROG_CYC, "R3 program busy length");
    expect_rd(16'd5, 8'hA5, "R2 program");
    prog(16'd5, 8'h3C); wait_idle();
    expect_rd(16'd5, 8'h24, "R2 AND of old and new");
    prog(16'd100, 8'h0F); wait_idle();
    expect_rd(16'd100, 8'h0F, "R2 main block program");

    prog(16'd6, 8'h00);
    expect_rd(16'd6, 8'hFF, "R9 read while busy");
    wait_idle();
    expect_rd(16'd6, 8'h00, "R2 after busy");

    wr(16'h5555, 8'hAA); wr(16'h1234, 8'h55); wr(16'h5555, 8'hA0); wr(16'd30, 8'h00);
    expect_busy(1'b0, "R8 bad unlock no op");
    expect_rd(16'd30, 8'hFF, "R8 bad unlock");
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h77); wr(16'd31, 8'h00);
    expect_rd(16'd31, 8'hFF, "R8 bad select");

    boot_lock_i = 1'b1;
    prog(16'd3, 8'h00); wait_idle();
    expect_rd(16'd3, 8'hFF, "R6 locked boot program");
    prog(16'd20, 8'h11); wait_idle();
    expect_rd(16'd20, 8'h11, "R6 param unaffected by lock");
    erase6(16'd2, 8'h30); wait_idle();
    expect_rd(16'd5, 8'h24, "R6 locked boot sector erase");

    prog(16'd40, 8'h00); wait_idle();
    prog(16'd70, 8'h00); wait_idle();
    erase6(16'd45, 8'h30);
    busy_len(n);
    chk(n, ERASE_CYC, "R3 erase busy length");
    expect_rd(16'd40, 8'hFF, "R4 target sector erased");
    expect_rd(16'd70, 8'h00, "R4 neighbour sector kept");
    expect_rd(16'd100, 8'h0F, "R4 other main kept");
    expect_rd(16'd20, 8'h11, "R4 param kept");

    erase6(16'h5555, 8'h10);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0);
    expect_busy(1'b1, "R7 still erasing");
    wait_idle();
    wr(16'd60, 8'h00);
    expect_rd(16'd60, 8'hFF, "R7 prefix during erase ignored");
    expect_rd(16'd5, 8'h24, "R5 locked boot kept");
    expect_rd(16'd20, 8'hFF, "R5 param erased");
    expect_rd(16'd70, 8'hFF, "R5 main erased");
    expect_rd(16'd100, 8'hFF, "R5 main2 erased");

    boot_lock_i = 1'b0;
    erase6(16'h5555, 8'h10); wait_idle();
    expect_rd(16'd5, 8'hFF, "R5 unlocked boot erased");
    expect_rd(16'd6, 8'hFF, "R5 unlocked boot erased 2");

    @(posedge clk_i); @(posedge clk_i);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule